// File: doc/BRIEF.md
# Dual-Lane Registered Parity Transceiver

This block moves two 8-bit data lanes, each with a companion parity bit, between two sides named A and B. Each direction, A to B and B to A, has its own storage stage with its own clock, its own pass-through control and one load enable per lane. With the pass-through control high, a lane follows its input with no clock. With it low, a lane loads on the rising clock edge when its load enable is set, and holds its value otherwise.

A mode input chooses between two uses. In the checked mode, the block builds a fresh parity bit for every outgoing lane from the stored data. It also checks every incoming lane and pulls a per-lane, per-side error flag low on a mismatch. A sense input picks odd or even parity for both jobs. In the bypass mode, the parity bits travel through the storage untouched, the block acts as a plain 18-bit registered path, and all error flags stay high.

The bidirectional pins are modelled as separate input, output and drive-enable ports on each side. Each side's drive is gated by its own enable input.

Top module: `dual_lane_parity_xcvr`

## Requirements
- R1: With a direction's pass-through input high, that direction's outputs follow its inputs within the same cycle, with no clock edge.
- R2: With pass-through low and a lane's load enable high, the lane's data and parity are captured from the source side on the rising edge of that direction's clock, and appear on the far side after that edge.
- R3: With pass-through low and a lane's load enable low, the lane's stored value is held across clock edges. A value seen while pass-through was high and sampled at a clock edge stays on the output after pass-through falls.
- R4: Load enables act per lane. Lane 0 uses data bits [7:0] and parity bit 0, and lane 1 uses data bits [15:8] and parity bit 1. Loading one lane leaves the other lane's stored value unchanged.
- R5: In checked mode (bypass input low), each outgoing parity bit is built from that lane's outgoing data. With the sense input at 1, data plus parity hold an odd number of ones. With the sense input at 0, they hold an even number.
- R6: In checked mode, the active-low error flag of a side's lane goes low exactly when that side's incoming 8 data bits plus incoming parity bit fail the selected parity sense. Flag bit n belongs to lane n.
- R7: With the bypass input high, outgoing parity bits equal the stored incoming parity bits, and every error flag on both sides is high whatever the data.
- R8: With a side's drive-enable input low, that side's drive-enable output is low and its data and parity outputs are zero. With the drive-enable input high, the drive-enable output is high.
- R9: A synchronous active-low reset clears the stored data and parity in both directions.
- R10: The two directions are independent. Clocking or making the B-to-A path transparent does not change the A-to-B outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Clock for the A-to-B storage |
| clk_ba | input | 1 | Clock for the B-to-A storage |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| le_ab | input | 1 | A-to-B pass-through (transparent when high) |
| le_ba | input | 1 | B-to-A pass-through (transparent when high) |
| cken_ab | input | 2 | A-to-B per-lane load enables |
| cken_ba | input | 2 | B-to-A per-lane load enables |
| par_bypass | input | 1 | High: parity logic bypassed; low: generate and check |
| odd_sense | input | 1 | 1 selects odd parity, 0 selects even |
| b_drive_en | input | 1 | Enables driving of side B |
| a_drive_en | input | 1 | Enables driving of side A |
| a_in | input | 16 | Side A incoming data, lane 1 in the upper byte |
| a_par_in | input | 2 | Side A incoming parity, one bit per lane |
| a_out | output | 16 | Side A outgoing data |
| a_par_out | output | 2 | Side A outgoing parity |
| a_oe | output | 1 | Side A drive enable (low stands for high impedance) |
| b_in | input | 16 | Side B incoming data |
| b_par_in | input | 2 | Side B incoming parity |
| b_out | output | 16 | Side B outgoing data |
| b_par_out | output | 2 | Side B outgoing parity |
| b_oe | output | 1 | Side B drive enable (low stands for high impedance) |
| err_a_n | output | 2 | Side A per-lane parity error, active low |
| err_b_n | output | 2 | Side B per-lane parity error, active low |

## Verification
The checker watches the cycle-level rules on every clock edge: the held value while a lane's load enable is low, a clocked capture of lane 0, the parity sense of the generated bits, the high error flags in bypass, and silenced outputs when a drive enable is off. The bench's scenarios are needed for the rest. These are the transparent path with no clock, the hand-off from transparent to latched, and partial loads where only one lane changes. They also cover injected errors on a single lane, the independence of the two directions, and a reset in the middle of traffic.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the dual-lane parity transceiver.
// Assumes: the storage mode is a pure function of the pass-through and load-enable inputs.
package xcvr_pkg;

    localparam int DEF_LANES  = 2;
    localparam int DEF_LANE_W = 8;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_LOAD = 2'd1,
        ST_HOLD = 2'd2
    } store_mode_e;

    // Decode the storage mode of one lane; pass-through wins over load.
    function automatic store_mode_e pick_mode(input logic pass, input logic load);
        if (pass)      return ST_PASS;
        else if (load) return ST_LOAD;
        else           return ST_HOLD;
    endfunction

endpackage

// File: rtl/lane_store.sv
// One lane of storage for one direction: data plus parity bit.
// Transparent while pass is high, loads on the clock edge while pass or load
// is set, and holds otherwise. The register also samples during pass, so the
// value seen at the last edge remains after pass falls.
// Assumes: rst_n is synchronous to clk.
module lane_store
    import xcvr_pkg::*;
#(
    parameter int W = DEF_LANE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pass,
    input  logic         load,
    input  logic [W-1:0] d_in,
    input  logic         p_in,
    output logic [W-1:0] d_out,
    output logic         p_out
);
    localparam int SW = W + 1;

    store_mode_e      mode;
    logic [SW-1:0]    held;

    // Decode the storage mode from the controls.
    always_comb mode = pick_mode(pass, load);

    // Storage register: cleared by reset, refreshed unless holding.
    always_ff @(posedge clk) begin
        if (!rst_n)              held <= '0;
        else if (mode != ST_HOLD) held <= {p_in, d_in};
    end

    // Output selection: live input when transparent, stored value otherwise.
    always_comb begin
        if (mode == ST_PASS) {p_out, d_out} = {p_in, d_in};
        else                 {p_out, d_out} = held;
    end
endmodule

// File: rtl/lane_parity.sv
// Parity unit for one lane: builds the outgoing parity bit from stored data,
// and checks an incoming data plus parity group. Bypass passes the stored
// parity through and forces the error flag high.
// Assumes: odd_sense=1 means the group must hold an odd count of ones.
module lane_parity #(
    parameter int W = 8
) (
    input  logic         bypass,
    input  logic         odd_sense,
    input  logic [W-1:0] gen_data,
    input  logic         gen_par_in,
    output logic         gen_par_out,
    input  logic [W-1:0] chk_data,
    input  logic         chk_par,
    output logic         err_n
);
    // Generation: the bit that makes the group match the sense, or passthrough.
    always_comb gen_par_out = bypass ? gen_par_in : ((^gen_data) ^ odd_sense);

    // Checking: the flag stays high when the group's ones count matches the sense.
    always_comb err_n = bypass | ((^{chk_data, chk_par}) == odd_sense);
endmodule

// File: rtl/xcvr_path.sv
// One direction of the transceiver: per-lane storage, parity generation on the
// destination side, parity checking of the source side, and drive gating.
// Assumes: one clock for the whole direction, per-lane load enables.
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int W     = DEF_LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pass,
    input  logic [LANES-1:0]   load,
    input  logic               bypass,
    input  logic               odd_sense,
    input  logic               drive_en,
    input  logic [LANES*W-1:0] src_data,
    input  logic [LANES-1:0]   src_par,
    output logic [LANES*W-1:0] dst_data,
    output logic [LANES-1:0]   dst_par,
    output logic               dst_oe,
    output logic [LANES-1:0]   src_err_n
);
    logic [LANES*W-1:0] st_data;
    logic [LANES-1:0]   st_par;
    logic [LANES-1:0]   gen_par;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_store #(.W(W)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .pass  (pass),
            .load  (load[l]),
            .d_in  (src_data[l*W +: W]),
            .p_in  (src_par[l]),
            .d_out (st_data[l*W +: W]),
            .p_out (st_par[l])
        );

        lane_parity #(.W(W)) u_par (
            .bypass      (bypass),
            .odd_sense   (odd_sense),
            .gen_data    (st_data[l*W +: W]),
            .gen_par_in  (st_par[l]),
            .gen_par_out (gen_par[l]),
            .chk_data    (src_data[l*W +: W]),
            .chk_par     (src_par[l]),
            .err_n       (src_err_n[l])
        );
    end

    // Drive gating: zero outputs and a low enable stand for high impedance.
    always_comb begin
        dst_oe   = drive_en;
        dst_data = drive_en ? st_data : '0;
        dst_par  = drive_en ? gen_par : '0;
    end
endmodule

// File: rtl/dual_lane_parity_xcvr.sv
// Top of the dual-lane registered parity transceiver: two independent
// direction paths. The A-to-B path checks side A and drives side B; the
// B-to-A path checks side B and drives side A.
// Assumes: rst_n is synchronous to both clocks.
module dual_lane_parity_xcvr
    import xcvr_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst_n,
    input  logic             le_ab,
    input  logic             le_ba,
    input  logic [LANES-1:0] cken_ab,
    input  logic [LANES-1:0] cken_ba,
    input  logic             par_bypass,
    input  logic             odd_sense,
    input  logic             b_drive_en,
    input  logic             a_drive_en,
    input  logic [BUS_W-1:0] a_in,
    input  logic [LANES-1:0] a_par_in,
    output logic [BUS_W-1:0] a_out,
    output logic [LANES-1:0] a_par_out,
    output logic             a_oe,
    input  logic [BUS_W-1:0] b_in,
    input  logic [LANES-1:0] b_par_in,
    output logic [BUS_W-1:0] b_out,
    output logic [LANES-1:0] b_par_out,
    output logic             b_oe,
    output logic [LANES-1:0] err_a_n,
    output logic [LANES-1:0] err_b_n
);
    xcvr_path #(.LANES(LANES), .W(LANE_W)) u_path_ab (
        .clk       (clk_ab),
        .rst_n     (rst_n),
        .pass      (le_ab),
        .load      (cken_ab),
        .bypass    (par_bypass),
        .odd_sense (odd_sense),
        .drive_en  (b_drive_en),
        .src_data  (a_in),
        .src_par   (a_par_in),
        .dst_data  (b_out),
        .dst_par   (b_par_out),
        .dst_oe    (b_oe),
        .src_err_n (err_a_n)
    );

    xcvr_path #(.LANES(LANES), .W(LANE_W)) u_path_ba (
        .clk       (clk_ba),
        .rst_n     (rst_n),
        .pass      (le_ba),
        .load      (cken_ba),
        .bypass    (par_bypass),
        .odd_sense (odd_sense),
        .drive_en  (a_drive_en),
        .src_data  (b_in),
        .src_par   (b_par_in),
        .dst_data  (a_out),
        .dst_par   (a_par_out),
        .dst_oe    (a_oe),
        .src_err_n (err_b_n)
    );
endmodule

// File: rtl/xcvr_checker.sv
// Cycle rules for the transceiver, watched at its ports; bound to the top.
// Assumes: both clocks are running while rst_n is sampled.
module xcvr_checker #(
    parameter int LANES = 2,
    parameter int W     = 8,
    localparam int BW   = LANES * W
) (
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             rst_n,
    input logic             le_ab,
    input logic [LANES-1:0] cken_ab,
    input logic             par_bypass,
    input logic             odd_sense,
    input logic             b_drive_en,
    input logic             a_drive_en,
    input logic [BW-1:0]    a_in,
    input logic [BW-1:0]    a_out,
    input logic [LANES-1:0] a_par_out,
    input logic             a_oe,
    input logic [BW-1:0]    b_out,
    input logic [LANES-1:0] b_par_out,
    input logic             b_oe,
    input logic [LANES-1:0] err_a_n,
    input logic [LANES-1:0] err_b_n
);
    // Lane 0 loads on the edge, then shows the source value from that edge.
    p_lane0_capture_r2: assert property (@(posedge clk_ab) disable iff (!rst_n)
        ($past(rst_n && !le_ab && cken_ab[0] && b_drive_en) && !le_ab && b_drive_en)
        |-> (b_out[W-1:0] == $past(a_in[W-1:0])));

    // No lane loads: the driven B data does not move.
    p_hold_all_r3: assert property (@(posedge clk_ab) disable iff (!rst_n)
        ($past(rst_n && !le_ab && (cken_ab == '0) && b_drive_en) && !le_ab && b_drive_en)
        |-> $stable(b_out));

    // Generated parity on B matches the sense for the top lane.
    p_gen_sense_r5: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!par_bypass && b_drive_en)
        |-> ((^{b_out[BW-1 -: W], b_par_out[LANES-1]}) == odd_sense));

    // Bypass keeps every error flag high on both sides.
    p_bypass_flags_r7: assert property (@(posedge clk_ab) disable iff (!rst_n)
        par_bypass |-> ((&err_a_n) && (&err_b_n)));

    // B side silent when its drive is off.
    p_b_silent_r8: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !b_drive_en |-> (!b_oe && (b_out == '0) && (b_par_out == '0)));

    // A side silent when its drive is off.
    p_a_silent_r8: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !a_drive_en |-> (!a_oe && (a_out == '0) && (a_par_out == '0)));
endmodule

bind dual_lane_parity_xcvr xcvr_checker #(.LANES(LANES), .W(LANE_W)) u_chk (
    .clk_ab     (clk_ab),
    .clk_ba     (clk_ba),
    .rst_n      (rst_n),
    .le_ab      (le_ab),
    .cken_ab    (cken_ab),
    .par_bypass (par_bypass),
    .odd_sense  (odd_sense),
    .b_drive_en (b_drive_en),
    .a_drive_en (a_drive_en),
    .a_in       (a_in),
    .a_out      (a_out),
    .a_par_out  (a_par_out),
    .a_oe       (a_oe),
    .b_out      (b_out),
    .b_par_out  (b_par_out),
    .b_oe       (b_oe),
    .err_a_n    (err_a_n),
    .err_b_n    (err_b_n)
);

// File: tb/tb_dual_lane_parity_xcvr.sv
module tb_dual_lane_parity_xcvr;
    logic        clk = 1'b0;
    logic        rst_n, le_ab, le_ba, par_bypass, odd_sense, b_drive_en, a_drive_en;
    logic [1:0]  cken_ab, cken_ba, a_par_in, b_par_in;
    logic [15:0] a_in, b_in;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_par_out, b_par_out, err_a_n, err_b_n;
    logic        a_oe, b_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dual_lane_parity_xcvr dut (
        .clk_ab(clk), .clk_ba(clk), .rst_n(rst_n),
        .le_ab(le_ab), .le_ba(le_ba), .cken_ab(cken_ab), .cken_ba(cken_ba),
        .par_bypass(par_bypass), .odd_sense(odd_sense),
        .b_drive_en(b_drive_en), .a_drive_en(a_drive_en),
        .a_in(a_in), .a_par_in(a_par_in), .a_out(a_out), .a_par_out(a_par_out), .a_oe(a_oe),
        .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe),
        .err_a_n(err_a_n), .err_b_n(err_b_n)
    );

    // Vector: {le, cken[1:0], par_in[1:0], data[15:0], expected B data[15:0]}
    localparam int NV = 10;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 2'b00, 2'b00, 16'h1234, 16'h1234},
        {1'b0, 2'b00, 2'b01, 16'hABCD, 16'h1234},
        {1'b0, 2'b11, 2'b10, 16'h5A3C, 16'h5A3C},
        {1'b0, 2'b01, 2'b11, 16'hFF00, 16'h5A00},
        {1'b0, 2'b10, 2'b00, 16'h0077, 16'h0000},
        {1'b0, 2'b00, 2'b01, 16'hC3C3, 16'h0000},
        {1'b1, 2'b00, 2'b10, 16'h8001, 16'h8001},
        {1'b0, 2'b01, 2'b11, 16'h7E42, 16'h8042},
        {1'b0, 2'b11, 2'b00, 16'hFFFF, 16'hFFFF},
        {1'b0, 2'b00, 2'b11, 16'h0000, 16'hFFFF}
    };

    function automatic logic [1:0] want_par(input logic [15:0] d, input logic odd);
        return {(^d[15:8]) ^ odd, (^d[7:0]) ^ odd};
    endfunction

    function automatic logic [1:0] want_err(input logic [15:0] d, input logic [1:0] p,
                                            input logic odd);
        return {(^{d[15:8], p[1]}) == odd, (^{d[7:0], p[0]}) == odd};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        logic [15:0] saved;
        rst_n = 0; le_ab = 0; le_ba = 0; cken_ab = 0; cken_ba = 0;
        par_bypass = 0; odd_sense = 1; b_drive_en = 1; a_drive_en = 1;
        a_in = 0; b_in = 0; a_par_in = 2'b11; b_par_in = 2'b11;
        repeat (2) @(posedge clk);
        #2;
        check("R9 reset B data", 32'(b_out), 32'h0);
        check("R9 reset A data", 32'(a_out), 32'h0);
        check("R5 reset parity odd", 32'(b_par_out), 32'h3);
        check("R8 drive enables", {30'h0, a_oe, b_oe}, 32'h3);
        @(negedge clk) rst_n = 1;

        // Table walk: modes, lane loads, parity and checking on side A
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {le_ab, cken_ab, a_par_in, a_in} = VEC[i][36:16];
            @(posedge clk);
            #2;
            check($sformatf("R1/R2/R3/R4 vec %0d", i), 32'(b_out), 32'(VEC[i][15:0]));
            check($sformatf("R5 vec %0d", i), 32'(b_par_out), 32'(want_par(VEC[i][15:0], 1'b1)));
            check($sformatf("R6 vec %0d", i), 32'(err_a_n),
                  32'(want_err(VEC[i][31:16], VEC[i][33:32], 1'b1)));
        end

        // Even sense on held FFFF data
        @(negedge clk) odd_sense = 0;
        #1 check("R5 even sense", 32'(b_par_out), 32'h0);
        @(negedge clk) odd_sense = 1;

        // Injected errors on side B
        b_in = 16'h0301; b_par_in = 2'b00;
        #1 check("R6 lane1 error only", 32'(err_b_n), 32'h1);
        b_par_in = 2'b11;
        #1 check("R6 lane0 error only", 32'(err_b_n), 32'h2);

        // Bypass: parity passes, flags high
        @(negedge clk);
        par_bypass = 1; le_ab = 1; a_in = 16'h0F01; a_par_in = 2'b01;
        #1;
        check("R7 parity passthrough", 32'(b_par_out), 32'h1);
        check("R7 flags A high", 32'(err_a_n), 32'h3);
        check("R7 flags B high", 32'(err_b_n), 32'h3);
        check("R1 transparent A to B", 32'(b_out), 32'h0F01);
        @(posedge clk);
        @(negedge clk) begin par_bypass = 0; le_ab = 0; end

        // Drive gating on side B
        b_drive_en = 0;
        #1 check("R8 B silent", {13'h0, b_oe, b_par_out, b_out}, 32'h0);
        @(negedge clk) b_drive_en = 1;
        #1 check("R3 held after pass", 32'(b_out), 32'h0F01);

        // B-to-A traffic leaves A-to-B alone
        saved = b_out;
        @(negedge clk);
        le_ba = 0; cken_ba = 2'b11; b_in = 16'h1357; b_par_in = 2'b00;
        @(posedge clk); #2;
        check("R10 B to A load", 32'(a_out), 32'h1357);
        check("R10 A to B unchanged", 32'(b_out), 32'(saved));
        @(negedge clk);
        cken_ba = 2'b00; le_ba = 1; b_in = 16'h2468;
        #1 check("R1 transparent B to A", 32'(a_out), 32'h2468);
        check("R10 A to B unchanged again", 32'(b_out), 32'(saved));

        // Reset in mid traffic
        @(negedge clk) begin le_ba = 0; rst_n = 0; end
        @(posedge clk); #2;
        check("R9 mid reset B", 32'(b_out), 32'h0);
        check("R9 mid reset A", 32'(a_out), 32'h0);
        @(negedge clk) rst_n = 1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule